// File: doc/BRIEF.md
# MDIO Management Frame Sequencer

This block carries out clause-22 management reads and writes to an external PHY. A single write to its command register starts a transaction. The block then builds the whole serial frame in hardware, with no bit-banging by software. The frame is a 32-bit run of ones, then start, opcode, PHY address and register address. A write follows these with the turnaround pattern and 16 data bits. A read releases the line and samples the 18 bits that the PHY returns.

The block generates the management clock MDC from the system clock through a parameterised divider. Each MDC half-period lasts `HALF_DIV` system clocks, and MDC stays low while the block is idle. The block drives MDIO through a data output and an output enable, so an external tristate pad can join the two directions. Software polls bit 31 of the same register, which is the busy flag. Once that bit clears after a read, the low 16 bits hold the data returned by the PHY.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After synchronous reset, the read-back word is all zero, MDC is low and the MDIO output enable is low.
- R2: Every frame opens with 32 bit slots of MDIO driven to one with the output enable high.
- R3: A read sends 01, then opcode 10, then the 5-bit PHY address, then the 5-bit register address, most significant bit first, in slots 32 to 45.
- R4: During a read, the output enable is low from slot 46 to slot 63. MDIO is sampled in all 18 of those slots. The last 16 samples, with the first-sampled bit in the MSB, appear in read-back bits 15:0 once busy clears. Bits 30:16 read as zero.
- R5: A write sends 01, then opcode 01, PHY address, register address, turnaround 10 and then 16 data bits, all MSB first, with the output enable high in all 64 slots.
- R6: The command word carries the opcode in bits 29:28, where 10 means read and 01 means write. The PHY address sits in bits 27:23, the register address in bits 22:18 and the write data in bits 15:0. Opcodes 00 and 11 start nothing: busy stays low and MDC stays low.
- R7: Read-back bit 31 is high starting with the cycle after an accepted command. It stays high for exactly 64 × 2 × `HALF_DIV` cycles.
- R8: MDIO changes only while MDC is low. Each new bit appears together with the falling edge of MDC, and incoming data is sampled on the rising edge.
- R9: A command written while busy is high is ignored. The frame in progress, its length and its result are unchanged, and no further frame follows.
- R10: MDC has a period of 2 × `HALF_DIV` system clocks within a frame, and it is low whenever busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_wdata | input | 32 | Command word (opcode, addresses, write data) |
| cmd_rdata | output | 32 | Bit 31 busy, bits 15:0 read result |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe | output | 1 | MDIO output enable (high = drive) |
| mdio_i | input | 1 | MDIO input data from the pad |

## Verification
A PHY model in the bench records every bit on the rising edge of MDC. It sends back a different 16-bit pattern for each read, including all ones and a single low bit. This catches an engine that keeps the wrong 16 of the 18 sampled bits or reverses their order. Writes use extreme addresses and data to expose a field shifted by one position, and read frames are checked for release of the output enable exactly at the turnaround. A design that kept the enable high one slot too long would fight the PHY, and one that released it early would corrupt the register address. A command arriving in the last busy cycle is a separate case: an off-by-one in the busy check would start a second, unrequested frame. Opcodes 00 and 11 are applied to show that they leave MDC idle.

// File: rtl/mdio_eng_pkg.sv
package mdio_eng_pkg;

  // Clause-22 frame geometry
  localparam int PRE_BITS  = 32;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int HDR_BITS  = 4 + 2 * ADDR_W;
  localparam int TAIL_BITS = 2 + DATA_W;
  localparam int FRAME_W   = PRE_BITS + HDR_BITS + TAIL_BITS;
  localparam int SLOT_W    = $clog2(FRAME_W);
  localparam int RELEASE_SLOT = PRE_BITS + HDR_BITS;

  // Command word layout
  localparam int CMD_W     = 32;
  localparam int BUSY_BIT  = 31;
  localparam int OP_LO     = 28;
  localparam int PHY_LO    = 23;
  localparam int REG_LO    = 18;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_RSVD  = 2'b11
  } mdio_op_e;

endpackage

// File: rtl/mdio_clk_timer.sv
module mdio_clk_timer #(
  parameter int HALF_DIV = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic clear,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CNT_W = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] RISE_AT = CNT_W'(HALF_DIV - 1);
  localparam logic [CNT_W-1:0] FALL_AT = CNT_W'(2 * HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    rise_stb = run && (cnt == RISE_AT);
    fall_stb = run && (cnt == FALL_AT);
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (run) begin
      if (fall_stb) cnt <= '0;
      else          cnt <= cnt + 1'b1;
      if (rise_stb) mdc <= 1'b1;
      if (fall_stb) mdc <= 1'b0;
    end
  end

  // MDC only goes high one cycle after a rise strobe (R10)
  p_mdc_rise_on_strobe_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(mdc) |-> $past(rise_stb));

endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
  import mdio_eng_pkg::*;
(
  input  logic                op_read,
  input  logic [ADDR_W-1:0]   phy_addr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [FRAME_W-1:0]  frame,
  output logic [FRAME_W-1:0]  drive
);
  logic [TAIL_BITS-1:0] tail;
  logic [1:0]           opc;

  always_comb begin
    opc   = op_read ? 2'b10 : 2'b01;
    tail  = op_read ? {TAIL_BITS{1'b0}} : {2'b10, wdata};
    frame = {{PRE_BITS{1'b1}}, 2'b01, opc, phy_addr, reg_addr, tail};
    drive = {{(PRE_BITS + HDR_BITS){1'b1}}, {TAIL_BITS{~op_read}}};
  end

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_eng_pkg::*;
#(
  parameter int HALF_DIV = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  output logic [CMD_W-1:0]  cmd_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_W - 1);
  localparam logic [SLOT_W-1:0] REL_SLOT  = SLOT_W'(RELEASE_SLOT);

  mdio_op_e             cmd_op;
  logic                 accept;
  logic                 busy;
  logic                 is_read;
  logic [SLOT_W-1:0]    slot;
  logic [FRAME_W-1:0]   tx_sh;
  logic [FRAME_W-1:0]   oe_sh;
  logic [DATA_W-1:0]    rx_sh;
  logic [FRAME_W-1:0]   new_frame;
  logic [FRAME_W-1:0]   new_drive;
  logic                 rise_stb;
  logic                 fall_stb;
  logic [3:0]           cmd_unused_bits;

  assign cmd_unused_bits = {cmd_wdata[31:30], cmd_wdata[17:16]};
  assign cmd_op = mdio_op_e'(cmd_wdata[OP_LO +: 2]);
  assign accept = cmd_we && !busy && (cmd_op == OP_READ || cmd_op == OP_WRITE);

  mdio_frame_build u_build (
    .op_read  (cmd_op == OP_READ),
    .phy_addr (cmd_wdata[PHY_LO +: ADDR_W]),
    .reg_addr (cmd_wdata[REG_LO +: ADDR_W]),
    .wdata    (cmd_wdata[DATA_W-1:0]),
    .frame    (new_frame),
    .drive    (new_drive)
  );

  mdio_clk_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .clear    (accept),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      is_read <= 1'b0;
      slot    <= '0;
      tx_sh   <= '0;
      oe_sh   <= '0;
      rx_sh   <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      is_read <= (cmd_op == OP_READ);
      slot    <= '0;
      tx_sh   <= new_frame;
      oe_sh   <= new_drive;
    end else if (busy) begin
      if (rise_stb && is_read)
        rx_sh <= {rx_sh[DATA_W-2:0], mdio_i};
      if (fall_stb) begin
        if (slot == LAST_SLOT) begin
          busy  <= 1'b0;
          tx_sh <= '0;
          oe_sh <= '0;
        end else begin
          slot  <= slot + 1'b1;
          tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
          oe_sh <= {oe_sh[FRAME_W-2:0], 1'b0};
        end
      end
    end
  end

  assign mdio_o    = tx_sh[FRAME_W-1];
  assign mdio_oe   = oe_sh[FRAME_W-1];
  assign cmd_rdata = {busy, {(CMD_W - 1 - DATA_W){1'b0}}, rx_sh};

  // New MDIO bits appear only with a falling MDC edge (R8)
  p_mdio_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));

  // Read frames release the line from the turnaround on (R4)
  p_read_release_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && is_read && (slot >= REL_SLOT)) |-> !mdio_oe);

  // Idle line: clock low and output released (R10)
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mdc && !mdio_oe));

  // A command during busy does not restart the frame (R9)
  p_no_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_we && !(fall_stb && slot == LAST_SLOT)) |=>
      (busy && slot >= $past(slot)));

endmodule

// File: tb/mdio_cmd_engine_bench.sv
`timescale 1ns/1ps
module mdio_cmd_engine_bench;
  localparam int HALF   = 3;
  localparam int FW     = 64;
  localparam int TX_LEN = FW * 2 * HALF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_we = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic [31:0] cmd_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  typedef struct {
    logic [63:0] bits;
    logic [63:0] mask;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  logic [15:0] phy_resp = '0;

  mdio_cmd_engine #(.HALF_DIV(HALF)) u_mdio_cmd_engine (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .cmd_rdata(cmd_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- monitor / PHY model ----------------
  logic        prev_mdc = 1'b0;
  logic        prev_o   = 1'b0;
  logic [63:0] got_bits = '0;
  logic [63:0] got_oe   = '0;
  int          nrise    = 0;
  int          last_rise = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (mdc && prev_mdc && (mdio_o != prev_o))
        check(1'b0, "R8", "mdio moved while mdc high", 64'(mdio_o), 64'(prev_o));
      if (mdc && !prev_mdc) begin
        if (nrise > 0)
          check(cyc - last_rise == 2 * HALF, "R10", "mdc period",
                64'(cyc - last_rise), 64'(2 * HALF));
        last_rise = cyc;
        got_bits = {got_bits[62:0], mdio_o};
        got_oe   = {got_oe[62:0], mdio_oe};
        nrise++;
        if (nrise == FW) begin
          nrise = 0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R9", "unexpected frame", got_bits, 64'h0);
          end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(got_bits[63:32] == 32'hFFFF_FFFF && got_oe[63:32] == 32'hFFFF_FFFF,
                  "R2", "preamble", got_bits, e.bits);
            check((got_bits & e.mask) == (e.bits & e.mask), e.tag, "frame bits",
                  got_bits & e.mask, e.bits & e.mask);
            check(got_oe == e.mask, e.tag == "R3" ? "R4" : "R5", "output enable",
                  got_oe, e.mask);
          end
        end
      end
      if (!mdc && prev_mdc)
        mdio_i = (nrise >= 48 && nrise < 64) ? phy_resp[63 - nrise] : 1'b1;
      prev_mdc = mdc;
      prev_o   = mdio_o;
    end
  end

  // ---------------- driver ----------------
  task automatic run_txn(input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [15:0] wd,
                         input logic [15:0] resp, input int poke_at,
                         input string label);
    exp_t e;
    int   cnt;
    bit   rd;
    rd = (op == 2'b10);
    e.bits = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, ra,
              rd ? 18'h0 : {2'b10, wd}};
    e.mask = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    e.tag  = rd ? "R3" : "R5";
    exp_q.push_back(e);
    phy_resp = resp;
    @(negedge clk);
    cmd_wdata = {2'b00, op, phy, ra, 2'b00, wd};
    cmd_we    = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    check(cmd_rdata[31] == 1'b1, "R7", {label, " busy after command"},
          64'(cmd_rdata[31]), 64'h1);
    cnt = 0;
    while (cmd_rdata[31]) begin
      cnt++;
      if (cnt == poke_at) begin
        cmd_wdata = {2'b00, 2'b01, 5'h1F, 5'h0A, 2'b00, 16'h1234};
        cmd_we    = 1'b1;
      end else begin
        cmd_we = 1'b0;
      end
      @(negedge clk);
    end
    cmd_we = 1'b0;
    check(cnt == TX_LEN, "R7", {label, " busy length"}, 64'(cnt), 64'(TX_LEN));
    if (rd)
      check(cmd_rdata == {16'h0, resp}, "R4", {label, " read result"},
            64'(cmd_rdata), 64'({16'h0, resp}));
    repeat (3) @(negedge clk);
    check(cmd_rdata[31] == 1'b0 && mdc == 1'b0, "R9", {label, " stays idle"},
          64'({cmd_rdata[31], mdc}), 64'h0);
  endtask

  task automatic bad_op(input logic [1:0] op);
    @(negedge clk);
    cmd_wdata = {2'b00, op, 5'h03, 5'h04, 2'b00, 16'hBEEF};
    cmd_we    = 1'b1;
    @(negedge clk);
    cmd_we = 1'b0;
    check(cmd_rdata[31] == 1'b0, "R6", "invalid opcode busy", 64'(cmd_rdata[31]), 64'h0);
    repeat (2 * HALF + 2) @(negedge clk);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R6", "invalid opcode line idle",
          64'({mdc, mdio_oe}), 64'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cmd_rdata == 32'h0 && mdc == 1'b0 && mdio_oe == 1'b0, "R1", "reset state",
          64'({cmd_rdata, mdc, mdio_oe}), 64'h0);

    run_txn(2'b10, 5'h05, 5'h01, 16'h0000, 16'hA5C3, -1, "read p5 r1");
    run_txn(2'b01, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000, -1, "write all ones");
    run_txn(2'b01, 5'h00, 5'h00, 16'h0000, 16'h0000, -1, "write all zeros");
    run_txn(2'b10, 5'h10, 5'h11, 16'h0000, 16'hFFFF, -1, "read ones");
    run_txn(2'b10, 5'h01, 5'h1E, 16'h0000, 16'hFFFE, 40, "read poke mid");
    run_txn(2'b01, 5'h0A, 5'h15, 16'h8001, 16'h0000, TX_LEN, "write poke last");
    bad_op(2'b00);
    bad_op(2'b11);
    run_txn(2'b10, 5'h1B, 5'h04, 16'h0000, 16'h0001, -1, "read after bad ops");

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R9", "frames outstanding", 64'(exp_q.size()), 64'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(10 * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule